// File: doc/BRIEF.md
# Interleaved Half-Band Decimating Filter

This block is a half-band low-pass FIR that also halves the sample rate. It has eleven taps and uses no multipliers. One input bus carries several time-interleaved signed sample streams, and each stream is filtered on its own. A valid gate marks the useful input cycles. Consecutive gated samples rotate through streams 0 to STREAMS-1, and each stream keeps its own history. Cycles with the gate low leave the rotation and the history unchanged, so any gating pattern is allowed.

Every coefficient product is built from shifts and adds. The sum is divided by 128 (arithmetic shift, rounding toward minus infinity), which gives unity gain at DC. The passband peaks slightly above unity, so the result is clamped to the signed output range. Each stream emits an output only for every second round of input: the output gate shows bursts of STREAMS valid cycles separated by STREAMS idle cycles. Data and gate travel through a fixed four-register pipeline.

Top module: `hb_decim_filter`

## Requirements
- R1: For a stream whose samples are x[n] (x[n] is the newest), the filtered value is floor((2·(x[n]+x[n-10]) − 9·(x[n-2]+x[n-8]) + 39·(x[n-4]+x[n-6]) + 64·x[n-5]) / 128).
- R2: The k-th gated input sample after reset (counting from 0) belongs to stream k mod STREAMS. Each stream's history holds only that stream's samples.
- R3: A cycle with in_valid low changes neither the stream rotation nor any stream history, whatever in_data carries.
- R4: A stream's samples are numbered 0, 1, 2… from reset. Only odd-numbered samples produce an output. out_valid is high exactly four cycles after a gated input cycle whose sample is odd-numbered, and low in every other cycle.
- R5: An input accepted in cycle c shows its result on out_data in cycle c+4.
- R6: A filtered value above 2^(DATA_W-1)−1 is output as 2^(DATA_W-1)−1. A value below −2^(DATA_W-1) is output as −2^(DATA_W-1).
- R7: Synchronous reset returns the rotation to stream 0 with an even sample number, clears every stream history to zero, and drives out_valid low from the next cycle on.
- R8: out_data is zero in every cycle in which out_valid is low.
- R9: A constant input c on a stream gives outputs equal to c once eleven samples of that stream have arrived (unity DC gain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of rotation, history and output gate |
| in_data | input | DATA_W | Signed input sample |
| in_valid | input | 1 | High when in_data carries a sample |
| out_data | output | DATA_W | Signed filtered, decimated sample |
| out_valid | output | 1 | High when out_data carries a result |

## Verification
Two events can fall in the same clock: the stream rotation wraps, which flips the decimation phase, and the input gate drops. The bench provokes this with a pseudo-random gate that often goes low right at a round boundary. It also drives continuous, saturating and reset-interrupted traffic. Each cycle the bench compares out_valid and out_data against a model. The model keeps per-stream histories and a phase counter that move only on gated cycles, and it places every expected result exactly four cycles after its input. A phase that slips by one sample inverts the burst pattern, and an idle cycle that is wrongly taken as a sample shifts every following value.

// File: rtl/hb_pkg.sv
package hb_pkg;
   // eleven-tap symmetric half-band kernel, centre at index 5
   localparam int TAPS     = 11;
   localparam int CENTER   = 5;
   // taps sum to 2^SCALE_SH, so this shift restores unity gain
   localparam int SCALE_SH = 7;
   // pre-add carry bit plus headroom for a coefficient magnitude sum of 164
   localparam int GUARD_W  = 9;
endpackage

// File: rtl/hb_sequencer.sv
module hb_sequencer #(
   parameter int STREAMS = 4,
   localparam int IDX_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   output logic [IDX_W-1:0] idx_o,
   output logic             phase_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(STREAMS - 1);

   generate
      if (STREAMS == 1) begin : g_single
         logic phase_q;
         always_ff @(posedge clk) begin
            if (rst)         phase_q <= 1'b0;
            else if (in_vld) phase_q <= ~phase_q;
         end
         assign idx_o   = '0;
         assign phase_o = phase_q;
      end else begin : g_multi
         logic [IDX_W-1:0] idx_q;
         logic             phase_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               idx_q   <= '0;
               phase_q <= 1'b0;
            end else if (in_vld) begin
               if (idx_q == LAST) begin
                  idx_q   <= '0;
                  phase_q <= ~phase_q;
               end else begin
                  idx_q   <= idx_q + 1'b1;
               end
            end
         end
         assign idx_o   = idx_q;
         assign phase_o = phase_q;
      end
   endgenerate

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> ($stable(idx_o) && $stable(phase_o)));

   assert_idx_bound_R2: assert property (@(posedge clk) disable iff (rst)
      idx_o <= LAST);

   assert_round_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (in_vld && idx_o == LAST) |=> (idx_o == '0 && phase_o != $past(phase_o)));
endmodule

// File: rtl/hb_tap_line.sv
module hb_tap_line #(
   parameter int DATA_W  = 20,
   parameter int STREAMS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_vld,
   input  logic                     in_emit,
   input  logic signed [DATA_W-1:0] in_data,
   output logic signed [DATA_W-1:0] tap_o [hb_pkg::TAPS],
   output logic                     vld_o
);
   // stream interleaving turns tap spacing into a stride of STREAMS entries
   localparam int DEPTH = (hb_pkg::TAPS - 1) * STREAMS + 1;

   logic signed [DATA_W-1:0] line_q [DEPTH];
   logic                     vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      end else if (in_vld) begin
         line_q[0] <= in_data;
         for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= in_vld & in_emit;
   end

   generate
      for (genvar k = 0; k < hb_pkg::TAPS; k++) begin : g_tap
         assign tap_o[k] = line_q[k*STREAMS];
      end
   endgenerate
   assign vld_o = vld_q;

   assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> ($stable(line_q[0]) && $stable(line_q[DEPTH-1])));

   assert_line_load_R2: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> (line_q[0] == $past(in_data)));
endmodule

// File: rtl/hb_shift_add.sv
module hb_shift_add #(
   parameter int DATA_W = 20,
   parameter int ACC_W  = 29
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] tap_i [hb_pkg::TAPS],
   input  logic                     vld_i,
   output logic signed [ACC_W-1:0]  acc_o,
   output logic                     vld_o
);
   localparam int PW = DATA_W + 1;
   localparam int C  = hb_pkg::CENTER;

   logic signed [PW-1:0]     outer_q, mid_q, inner_q;
   logic signed [DATA_W-1:0] ctr_q;
   logic                     pair_vld_q;
   logic signed [ACC_W-1:0]  acc_q;
   logic                     acc_vld_q;

   function automatic logic signed [PW-1:0] pre_add(input logic signed [DATA_W-1:0] a,
                                                    input logic signed [DATA_W-1:0] b);
      return {a[DATA_W-1], a} + {b[DATA_W-1], b};
   endfunction

   function automatic logic signed [ACC_W-1:0] widen(input logic signed [PW-1:0] v);
      return {{(ACC_W-PW){v[PW-1]}}, v};
   endfunction

   // stage A: fold the symmetric pairs
   always_ff @(posedge clk) begin
      outer_q <= pre_add(tap_i[C-5], tap_i[C+5]);
      mid_q   <= pre_add(tap_i[C-3], tap_i[C+3]);
      inner_q <= pre_add(tap_i[C-1], tap_i[C+1]);
      ctr_q   <= tap_i[C];
   end

   // stage B: 2 = 1<<1, 9 = 8+1, 39 = 32+4+2+1, 64 = 1<<6
   logic signed [ACC_W-1:0] eo, em, ei, ec, acc_d;
   always_comb begin
      eo    = widen(outer_q);
      em    = widen(mid_q);
      ei    = widen(inner_q);
      ec    = {{(ACC_W-DATA_W){ctr_q[DATA_W-1]}}, ctr_q};
      acc_d = (eo <<< 1) - (em <<< 3) - em
            + (ei <<< 5) + (ei <<< 2) + (ei <<< 1) + ei
            + (ec <<< 6);
   end

   always_ff @(posedge clk) acc_q <= acc_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         pair_vld_q <= 1'b0;
         acc_vld_q  <= 1'b0;
      end else begin
         pair_vld_q <= vld_i;
         acc_vld_q  <= pair_vld_q;
      end
   end

   assign acc_o = acc_q;
   assign vld_o = acc_vld_q;
endmodule

// File: rtl/hb_saturate.sv
module hb_saturate #(
   parameter int DATA_W = 20,
   parameter int ACC_W  = 29
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [ACC_W-1:0]  acc_i,
   input  logic                     vld_i,
   output logic signed [DATA_W-1:0] data_o,
   output logic                     vld_o
);
   localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [ACC_W-1:0]  scaled, clamped;
   logic signed [DATA_W-1:0] data_q;
   logic                     vld_q;

   always_comb begin
      scaled = acc_i >>> hb_pkg::SCALE_SH;
      if (scaled > HI)      clamped = HI;
      else if (scaled < LO) clamped = LO;
      else                  clamped = scaled;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         vld_q  <= vld_i;
         data_q <= vld_i ? clamped[DATA_W-1:0] : '0;
      end
   end

   assign data_o = data_q;
   assign vld_o  = vld_q;

   assert_clip_hi_R6: assert property (@(posedge clk) disable iff (rst)
      (vld_i && scaled > HI) |=> (data_o == HI[DATA_W-1:0]));

   assert_clip_lo_R6: assert property (@(posedge clk) disable iff (rst)
      (vld_i && scaled < LO) |=> (data_o == LO[DATA_W-1:0]));
endmodule

// File: rtl/hb_decim_filter.sv
module hb_decim_filter #(
   parameter int DATA_W  = 20,
   parameter int STREAMS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic                     in_valid,
   output logic signed [DATA_W-1:0] out_data,
   output logic                     out_valid
);
   localparam int ACC_W = DATA_W + hb_pkg::GUARD_W;
   localparam int IDX_W = (STREAMS > 1) ? $clog2(STREAMS) : 1;

   generate
      if (STREAMS < 1) begin : g_bad_streams
         $error("hb_decim_filter: STREAMS must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("hb_decim_filter: DATA_W must be at least 8");
      end
   endgenerate

   logic [IDX_W-1:0]         idx;
   logic                     phase;
   logic signed [DATA_W-1:0] taps [hb_pkg::TAPS];
   logic                     tap_vld;
   logic signed [ACC_W-1:0]  acc;
   logic                     acc_vld;

   hb_sequencer #(.STREAMS(STREAMS)) u_seq (
      .clk(clk), .rst(rst), .in_vld(in_valid), .idx_o(idx), .phase_o(phase)
   );

   hb_tap_line #(.DATA_W(DATA_W), .STREAMS(STREAMS)) u_line (
      .clk(clk), .rst(rst), .in_vld(in_valid), .in_emit(phase),
      .in_data(in_data), .tap_o(taps), .vld_o(tap_vld)
   );

   hb_shift_add #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst(rst), .tap_i(taps), .vld_i(tap_vld),
      .acc_o(acc), .vld_o(acc_vld)
   );

   hb_saturate #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sat (
      .clk(clk), .rst(rst), .acc_i(acc), .vld_i(acc_vld),
      .data_o(out_data), .vld_o(out_valid)
   );

   assert_gate_lat_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 4));

   assert_odd_only_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !phase) |=> !tap_vld);
endmodule

// File: tb/hb_decim_filter_bench.sv
module hb_decim_filter_bench;
   localparam int DW   = 20;
   localparam int L    = 4;
   localparam int MAXV = (1 << (DW-1)) - 1;
   localparam int MINV = -(1 << (DW-1));

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] in_data = '0;
   wire  signed [DW-1:0] out_data;
   wire  out_valid;

   always #10 clk = ~clk;

   hb_decim_filter #(.DATA_W(DW), .STREAMS(L)) u_hb_decim_filter (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
      .out_data(out_data), .out_valid(out_valid)
   );

   int    checks = 0, errors = 0;
   string req = "R7";
   int    hist [L][11];
   int    sidx = 0;
   bit    ph [L];
   int    rounds = 0;
   bit    eg [8];
   int    ed [8];
   int    cyc = 0;
   int    sat_hi = 0, sat_lo = 0;
   int    seed = 32'h1234_5678;

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return seed >>> 8;
   endfunction

   function automatic int model_out(int s);
      int y;
      y = 2*(hist[s][0] + hist[s][10]) - 9*(hist[s][2] + hist[s][8])
        + 39*(hist[s][4] + hist[s][6]) + 64*hist[s][5];
      y = y >>> 7;
      if (y > MAXV) begin y = MAXV; sat_hi++; end
      else if (y < MINV) begin y = MINV; sat_lo++; end
      return y;
   endfunction

   task automatic model_clear();
      for (int s = 0; s < L; s++) begin
         ph[s] = 1'b0;
         for (int k = 0; k < 11; k++) hist[s][k] = 0;
      end
      sidx = 0;
      rounds = 0;
      for (int i = 0; i < 8; i++) begin eg[i] = 1'b0; ed[i] = 0; end
   endtask

   task automatic check(bit ok, string r, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
      end
   endtask

   task automatic tick(bit v, int d);
      int slot, y;
      @(negedge clk);
      slot = cyc % 8;
      check(out_valid === eg[slot], "R4", int'(out_valid), int'(eg[slot]));
      check(int'(out_data) === ed[slot], eg[slot] ? req : "R8", int'(out_data), ed[slot]);
      eg[slot] = 1'b0;
      ed[slot] = 0;
      in_valid = v;
      in_data  = DW'(d);
      if (v) begin
         for (int k = 10; k > 0; k--) hist[sidx][k] = hist[sidx][k-1];
         hist[sidx][0] = d;
         slot = (cyc + 4) % 8;
         if (ph[sidx]) begin
            y = model_out(sidx);
            eg[slot] = 1'b1;
            ed[slot] = y;
         end
         ph[sidx] = ~ph[sidx];
         if (sidx == L-1) begin sidx = 0; rounds++; end
         else sidx++;
      end
      cyc++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      in_data = '0;
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      // R7: gate low right after reset
      check(out_valid === 1'b0, "R7", int'(out_valid), 0);
      check(int'(out_data) === 0, "R7", int'(out_data), 0);
   endtask

   task automatic drain();
      for (int i = 0; i < 6; i++) tick(1'b0, 0);
   endtask

   int sv;

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();

      // R1 R5: impulse in stream 0 and a negative impulse in stream 2
      req = "R1 R5";
      tick(1, 1000); tick(1, 0); tick(1, -2048); tick(1, 0);
      for (int i = 0; i < 60; i++) tick(1, 0);
      drain();

      // R2: independent random streams, continuous gate
      req = "R2";
      for (int i = 0; i < 160; i++) tick(1, rnd() % (MAXV + 1));
      drain();

      // R3: irregular gate, garbage data on idle cycles
      req = "R3";
      for (int i = 0; i < 400; i++) begin
         if ((rnd() & 3) == 0) tick(0, rnd() % (MAXV + 1));
         else                  tick(1, (rnd() % 4096));
      end
      drain();

      // R9: constant input settles to itself
      do_reset();
      req = "R9";
      for (int i = 0; i < 80; i++) tick(1, 5000);
      for (int i = 0; i < 80; i++) tick(1, -777);
      drain();

      // R6: worst-case sign pattern; streams 0,1 positive, 2,3 negated
      do_reset();
      req = "R6";
      for (int r = 0; r < 30; r++) begin
         for (int s = 0; s < L; s++) begin
            int m;
            m = r % 10;
            if (m == 9 || m == 5 || m == 3 || m == 4) sv = MAXV;
            else if (m == 7 || m == 1)                sv = MINV;
            else                                      sv = 0;
            if (s >= 2) sv = (sv == MINV) ? MAXV : -sv;
            tick(1, sv);
         end
      end
      drain();
      check(sat_hi > 0, "R6", sat_hi, 1);
      check(sat_lo > 0, "R6", sat_lo, 1);

      // R7: reset mid-round, history must be gone afterwards
      req = "R7";
      for (int i = 0; i < 22; i++) tick(1, 30000 + i);
      do_reset();
      tick(1, 4000); tick(1, 0); tick(1, 0); tick(1, 0);
      for (int i = 0; i < 48; i++) tick(1, 0);
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule